// File: doc/BRIEF.md
# Serial SAR Converter Power and Conversion Controller

This block is the digital sequencer that sits inside a 12-bit successive-approximation converter with a three-wire serial port. It is modelled from the device side and runs on one fast system clock. It samples a conversion-start line, the serial bit clock and an active-low power-off pin. It then runs the bit-decision sequence against a digital comparator input and shifts the result out on a data pin. That pin is enabled only while a word is being sent. The analog parts are outside the block: the trial code drives an external DAC, and the comparator answer comes back as one bit.

The same two host lines also manage power. The host pulses the start line while holding the bit clock low: a few pulses drop the converter into a light power-down, and more pulses drop it into a deep one. A long enough high pulse on the bit clock brings it back. The deep state and the power-off pin both drop the reference. A readiness flag then stays low for a programmable settling count before it rises again. That flag leads every serial word, so the host learns from the data stream when results can be trusted.

Top module: `adc_conv_ctrl`

## Requirements
- R1: Under reset the power state is active (code 0), the data pin is not driven (sdoEn low), no conversion is busy and refReady is low.
- R2: A rising edge on convIn in the active state with no conversion running sets convBusy. The conversion then takes 14 rising edges of sclkIn, and convBusy falls on the 14th. A convIn edge while busy starts nothing.
- R3: Successive approximation: dacCode equals the bits already kept OR-ed with the current trial bit, and the first trial code is 0x800. A trial bit is kept when compIn is 1 at its decision edge. Once the conversion ends, dacCode holds the 12-bit result.
- R4: The serial word is 13 bits. On sclkIn rising edge 1, sdoEn rises and sdoData carries the refReady value. On rising edges 2 to 13, sdoData carries result bits 11 down to 0, each bit set at its own decision. On edge 14 sdoEn falls. sdoData changes only on an sclkIn rising edge.
- R5: Two convIn rising edges with sclkIn low and no sclkIn edge between them move the state from active to light power-down (code 1), and any conversion in progress is dropped.
- R6: Two more such edges in light power-down (four in all) move the state to deep power-down (code 2), and refReady falls.
- R7: Any sclkIn edge, rising or falling, clears the count of convIn pulses. Pulses separated by a bit-clock pulse never power the block down.
- R8: A convIn edge in light or deep power-down starts no conversion and leaves the data pin undriven.
- R9: A falling edge of sclkIn after it has been high for at least WAKE_MIN system cycles returns light or deep power-down to the active state. A shorter pulse leaves the state unchanged. Waking from light power-down keeps refReady, and a conversion may begin at once.
- R10: While shdnN is low the state is power-off (code 3), refReady is low, the data pin is undriven and no conversion runs. Releasing shdnN returns the state to active.
- R11: After reset, or on leaving deep power-down or power-off, refReady rises once SETTLE_CYCLES system cycles have been counted. Nothing shortens this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for all sampling and state |
| rstN | input | 1 | Active-low synchronous reset |
| convIn | input | 1 | Conversion start and power-down pulse line |
| sclkIn | input | 1 | Serial bit clock from the host |
| shdnN | input | 1 | Active-low power-off pin |
| compIn | input | 1 | Comparator decision: 1 means input is at or above dacCode |
| dacCode | output | 12 | Trial code for the DAC; holds the result after a conversion |
| sdoData | output | 1 | Serial data value |
| sdoEn | output | 1 | Data pin driver enable; low means high impedance |
| refReady | output | 1 | Reference settled flag |
| pwrState | output | 2 | 0 active, 1 light power-down, 2 deep power-down, 3 power-off |
| convBusy | output | 1 | Conversion sequence in progress |

## Verification
Two functions can fall on the same convIn edge. One edge both starts a conversion and counts as the first power-down pulse. The next edge then counts as the second pulse, and it has to abort that conversion in the same cycle it enters light power-down. The bench provokes this by sending two bare start pulses. It then checks that the state code is 1 and that the busy flag and the data enable are both low. A second overlap comes from pulling shdnN low in the middle of a serial word. The bench judges it by watching the enable and the flag fall together while the state moves to power-off.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2,
    PWR_OFF    = 2'd3
  } pwr_state_t;

  // strobes from the sequencer to the SAR datapath
  typedef struct packed {
    logic load;    // first bit-clock edge: send flag, set MSB trial
    logic decide;  // one bit decision and shift
    logic finish;  // last edge: release the data pin
    logic abort;   // power-down or power-off cut the conversion
    logic flag;    // reference readiness to place in the word
  } sar_strobe_t;
endpackage

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int NAP_PULSES    = 2,
  parameter int SLEEP_PULSES  = 4,
  parameter int WAKE_MIN      = 15,
  parameter int SETTLE_CYCLES = 750000
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        convIn,
  input  logic        sclkIn,
  input  logic        shdnN,
  output sar_strobe_t strb,
  output pwr_state_t  state,
  output logic        busy,
  output logic        refReady
);
  localparam int CONV_CLKS = RES_BITS + 2;
  localparam int CNT_W     = $clog2(CONV_CLKS + 1);
  localparam int PULSE_W   = $clog2(SLEEP_PULSES + 1);
  localparam int WAKE_W    = $clog2(WAKE_MIN + 1);
  localparam int SETTLE_W  = $clog2(SETTLE_CYCLES + 1);

  logic                convQ, clkQ;
  logic [CNT_W-1:0]    clkCnt;
  logic [PULSE_W-1:0]  pulseCnt;
  logic [WAKE_W-1:0]   highCnt;
  logic [SETTLE_W-1:0] settleCnt;

  logic convRise, clkRise, clkFall, pulseHit, goNap, goSleep, wakeOk, startConv, stepEdge;
  logic [PULSE_W-1:0] pulseNext;

  always_comb begin
    convRise  = convIn & ~convQ;
    clkRise   = sclkIn & ~clkQ;
    clkFall   = ~sclkIn & clkQ;
    pulseHit  = convRise & ~sclkIn & shdnN & ~clkQ &
                (state == PWR_ACTIVE || state == PWR_NAP);
    pulseNext = pulseCnt + 1'b1;
    goNap     = pulseHit && state == PWR_ACTIVE && pulseNext == PULSE_W'(NAP_PULSES);
    goSleep   = pulseHit && state == PWR_NAP && pulseNext == PULSE_W'(SLEEP_PULSES);
    wakeOk    = clkFall && highCnt >= WAKE_W'(WAKE_MIN) && shdnN;
    startConv = convRise && state == PWR_ACTIVE && shdnN && !busy;
    stepEdge  = busy && clkRise;

    strb.abort  = goNap | ~shdnN;
    strb.load   = stepEdge && clkCnt == '0;
    strb.decide = stepEdge && clkCnt >= CNT_W'(1) && clkCnt <= CNT_W'(RES_BITS);
    strb.finish = stepEdge && clkCnt == CNT_W'(CONV_CLKS - 1);
    strb.flag   = refReady;
  end

  // edge history, pulse counting and wake timing
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      convQ    <= 1'b0;
      clkQ     <= 1'b0;
      pulseCnt <= '0;
      highCnt  <= '0;
    end else begin
      convQ <= convIn;
      clkQ  <= sclkIn;
      if (clkRise || clkFall || !shdnN) pulseCnt <= '0;
      else if (pulseHit)                pulseCnt <= pulseNext;
      if (!sclkIn)                              highCnt <= '0;
      else if (highCnt != WAKE_W'(WAKE_MIN))    highCnt <= highCnt + 1'b1;
    end
  end

  // power state
  always_ff @(posedge sysClk) begin
    if (!rstN) state <= PWR_ACTIVE;
    else if (!shdnN) state <= PWR_OFF;
    else begin
      unique case (state)
        PWR_OFF:    state <= PWR_ACTIVE;
        PWR_ACTIVE: if (goNap) state <= PWR_NAP;
        PWR_NAP:    if (wakeOk) state <= PWR_ACTIVE;
                    else if (goSleep) state <= PWR_SLEEP;
        PWR_SLEEP:  if (wakeOk) state <= PWR_ACTIVE;
        default:    state <= PWR_ACTIVE;
      endcase
    end
  end

  // conversion step counter
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      clkCnt <= '0;
    end else if (strb.abort) begin
      busy   <= 1'b0;
      clkCnt <= '0;
    end else if (startConv) begin
      busy   <= 1'b1;
      clkCnt <= '0;
    end else if (stepEdge) begin
      clkCnt <= clkCnt + 1'b1;
      if (strb.finish) busy <= 1'b0;
    end
  end

  // reference settling timer
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      refReady  <= 1'b0;
      settleCnt <= '0;
    end else if (!shdnN || state == PWR_SLEEP || state == PWR_OFF) begin
      refReady  <= 1'b0;
      settleCnt <= '0;
    end else if (!refReady) begin
      if (settleCnt == SETTLE_W'(SETTLE_CYCLES - 1)) refReady <= 1'b1;
      else settleCnt <= settleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sar_path.sv
module adc_sar_path
  import adc_ctrl_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  sar_strobe_t         strb,
  input  logic                compIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                sdoData,
  output logic                sdoEn
);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] kept, trial;

  assign dacCode = kept | trial;

  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      kept    <= '0;
      trial   <= '0;
      sdoData <= 1'b0;
      sdoEn   <= 1'b0;
    end else if (strb.abort || strb.finish) begin
      trial   <= '0;
      sdoData <= 1'b0;
      sdoEn   <= 1'b0;
    end else if (strb.load) begin
      kept    <= '0;
      trial   <= TOP_BIT;
      sdoData <= strb.flag;
      sdoEn   <= 1'b1;
    end else if (strb.decide) begin
      if (compIn) kept <= kept | trial;
      sdoData <= compIn;
      trial   <= trial >> 1;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int NAP_PULSES    = 2,
  parameter int SLEEP_PULSES  = 4,
  parameter int WAKE_MIN      = 15,
  parameter int SETTLE_CYCLES = 750000
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                convIn,
  input  logic                sclkIn,
  input  logic                shdnN,
  input  logic                compIn,
  output logic [RES_BITS-1:0] dacCode,
  output logic                sdoData,
  output logic                sdoEn,
  output logic                refReady,
  output logic [1:0]          pwrState,
  output logic                convBusy
);
  sar_strobe_t strb;
  pwr_state_t  state;

  adc_pwr_ctrl #(
    .RES_BITS(RES_BITS), .NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES),
    .WAKE_MIN(WAKE_MIN), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .sysClk(sysClk), .rstN(rstN), .convIn(convIn), .sclkIn(sclkIn), .shdnN(shdnN),
    .strb(strb), .state(state), .busy(convBusy), .refReady(refReady)
  );

  adc_sar_path #(.RES_BITS(RES_BITS)) u_path (
    .sysClk(sysClk), .rstN(rstN), .strb(strb), .compIn(compIn),
    .dacCode(dacCode), .sdoData(sdoData), .sdoEn(sdoEn)
  );

  assign pwrState = state;
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk (
  input logic       sysClk,
  input logic       rstN,
  input logic       sclkIn,
  input logic       shdnN,
  input logic       sdoData,
  input logic       sdoEn,
  input logic       refReady,
  input logic [1:0] pwrState,
  input logic       convBusy
);
  // R4
  sdo_within_conv_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    sdoEn |-> convBusy);

  // R4
  sdo_moves_on_rise_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && sdoData != $past(sdoData)) |-> ($past(sclkIn) && !$past(sclkIn, 2)));

  // R10
  off_quiet_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !shdnN |=> (pwrState == 2'd3 && !refReady && !sdoEn && !convBusy));

  // R8
  lowpower_idle_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (pwrState == 2'd1 || pwrState == 2'd2) |-> (!convBusy && !sdoEn));

  // R6
  sleep_no_ref_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (pwrState == 2'd2 && $past(pwrState) == 2'd2) |-> !refReady);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk u_chk (
  .sysClk(sysClk), .rstN(rstN), .sclkIn(sclkIn), .shdnN(shdnN), .sdoData(sdoData),
  .sdoEn(sdoEn), .refReady(refReady), .pwrState(pwrState), .convBusy(convBusy)
);

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
  localparam int RES    = 12;
  localparam int WAKE   = 15;
  localparam int SETTLE = 40;

  logic sysClk = 1'b0;
  logic rstN = 1'b0, convIn = 1'b0, sclkIn = 1'b0, shdnN = 1'b1;
  logic compIn;
  logic [RES-1:0] dacCode, vinReg = '0;
  logic sdoData, sdoEn, refReady, convBusy;
  logic [1:0] pwrState;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #2 sysClk = ~sysClk;

  // comparator model: input at or above trial code
  assign compIn = (vinReg >= dacCode);

  adc_conv_ctrl #(.RES_BITS(RES), .WAKE_MIN(WAKE), .SETTLE_CYCLES(SETTLE)) u_dut (
    .sysClk(sysClk), .rstN(rstN), .convIn(convIn), .sclkIn(sclkIn), .shdnN(shdnN),
    .compIn(compIn), .dacCode(dacCode), .sdoData(sdoData), .sdoEn(sdoEn),
    .refReady(refReady), .pwrState(pwrState), .convBusy(convBusy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic convPulse();
    convIn = 1'b1; tick(2);
    convIn = 1'b0; tick(2);
  endtask

  task automatic wakePulse();
    sclkIn = 1'b1; tick(WAKE + 5);
    sclkIn = 1'b0; tick(2);
  endtask

  task automatic runConv(input logic [RES-1:0] vin, input logic expFlag);
    logic [RES:0] word;
    word = '0;
    vinReg = vin;
    convPulse();
    chk("R2 busy after start", convBusy, 1);
    chk("R4 pin idle before edge 1", sdoEn, 0);
    for (int e = 1; e <= RES + 2; e++) begin
      sclkIn = 1'b1; tick(2);
      if (e == 1) begin
        chk("R4 enable on edge 1", sdoEn, 1);
        chk("R4 flag bit", sdoData, expFlag);
        word[RES] = sdoData;
      end else if (e <= RES + 1) begin
        chk("R4 enable during word", sdoEn, 1);
        chk("R3 decided bit", sdoData, vin[RES + 1 - e]);
        word[RES + 1 - e] = sdoData;
        if (e == RES + 1) chk("R2 busy before edge 14", convBusy, 1);
      end else begin
        chk("R4 enable drops on edge 14", sdoEn, 0);
        chk("R2 busy drops on edge 14", convBusy, 0);
      end
      if (e == 1) chk("R3 first trial code", dacCode, 12'h800);
      tick(2);
      sclkIn = 1'b0; tick(4);
    end
    chk("R3 result on dacCode", dacCode, vin);
    chk("R4 serial word", word, {expFlag, vin});
  endtask

  task automatic testReset();
    rstN = 1'b0; tick(3);
    chk("R1 state", pwrState, 0);
    chk("R1 sdoEn", sdoEn, 0);
    chk("R1 busy", convBusy, 0);
    chk("R1 refReady", refReady, 0);
    rstN = 1'b1;
    tick(SETTLE - 10);
    chk("R11 still settling", refReady, 0);
    tick(15);
    chk("R11 ready after settle", refReady, 1);
  endtask

  task automatic testConversions();
    runConv(12'hA5C, 1'b1);
    runConv(12'h000, 1'b1);
    runConv(12'hFFF, 1'b1);
  endtask

  task automatic testPulseClear();
    convPulse();
    sclkIn = 1'b1; tick(4); sclkIn = 1'b0; tick(4);
    convPulse();
    chk("R7 stays active", pwrState, 0);
    chk("R2 second start ignored while busy", convBusy, 1);
    chk("R7 word under way", sdoEn, 1);
  endtask

  task automatic testShutdown();
    shdnN = 1'b0; tick(3);
    chk("R10 state off", pwrState, 3);
    chk("R10 refReady low", refReady, 0);
    chk("R10 pin released", sdoEn, 0);
    chk("R10 conversion cut", convBusy, 0);
    convPulse();
    chk("R10 no start while off", convBusy, 0);
    shdnN = 1'b1; tick(2);
    chk("R10 back to active", pwrState, 0);
    chk("R11 low after power-off", refReady, 0);
    tick(SETTLE + 5);
    chk("R11 ready after power-off", refReady, 1);
  endtask

  task automatic testNap();
    convPulse();
    convPulse();
    chk("R5 light power-down", pwrState, 1);
    chk("R5 conversion dropped", convBusy, 0);
    chk("R5 pin released", sdoEn, 0);
    chk("R5 reference kept", refReady, 1);
    convPulse();
    chk("R8 no start in nap", convBusy, 0);
    chk("R8 pin idle in nap", sdoEn, 0);
    sclkIn = 1'b1; tick(4); sclkIn = 1'b0; tick(2);
    chk("R9 short pulse ignored", pwrState, 1);
    wakePulse();
    chk("R9 wake from nap", pwrState, 0);
    chk("R9 reference kept on wake", refReady, 1);
    runConv(12'h3C7, 1'b1);
  endtask

  task automatic testSleep();
    convPulse(); convPulse();
    chk("R5 nap on way to sleep", pwrState, 1);
    convPulse(); convPulse();
    chk("R6 deep power-down", pwrState, 2);
    tick(2);
    chk("R6 reference dropped", refReady, 0);
    convPulse();
    chk("R8 no start in sleep", convBusy, 0);
    chk("R8 state held in sleep", pwrState, 2);
    wakePulse();
    chk("R9 wake from sleep", pwrState, 0);
    chk("R11 low after sleep", refReady, 0);
    runConv(12'h801, 1'b0);
    chk("R11 ready after sleep", refReady, 1);
  endtask

  initial begin
    tick(2);
    testReset();
    testConversions();
    testPulseClear();
    testShutdown();
    testNap();
    testSleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule